// File: doc/BRIEF.md
# DDR2 Write Burst Sequencer

This block converts single write requests from an on-chip bus into the command and write-data activity of one DDR2 rank. Each request carries a flat address in memory-width units, a word count from 1 to 8, eight data words and eight per-beat byte-enable groups. The block keeps one open-row record per bank. It opens a row only when the target bank has no usable open row. It then issues the write command and, after the write latency, drives an 8-beat burst with per-byte mask outputs.

Pages stay open after a write. A row is closed only when its bank record has been marked stale by the invalidate input, or when a request needs a different row in that bank. Short transfers are always completed by masking the unused beats, so every burst on the pins is 8 beats long. Clock-phase and strobe generation at the pins, refresh, reads and memory initialisation belong to other blocks.

Top module: `ddr2_wr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the command pins carry NOP, `mem_wdata_en` is 0, `mem_wmask` is all ones, `wr_done` is 0 and `req_ready` is 1. All bank records start closed.
- R2: `req_addr` is split as {row, bank, column}, with the column in the low COL_W bits, the bank in the next BA_W bits and the row in the top ROW_W bits. The defaults give a 26-bit address, counted in halfwords when DQ_W is 16 (128 MB) and in words when DQ_W is 32 (256 MB). The bank is driven on `mem_bank` with every command. The row is driven on `mem_addr` with an activate, and the column with a write.
- R3: The command pins {cs_n, ras_n, cas_n, we_n} encode activate as 0011, write as 0100, precharge as 0010 and NOP as 0111. Every cycle without a command carries NOP. Address bit 10 is 0 during write and precharge, so there is no auto-precharge and the precharge closes a single bank.
- R4: A request to a closed bank puts an activate on the pins in the cycle after acceptance, and a write TRCD cycles after the activate.
- R5: A request whose bank holds the same row with a valid record puts the write on the pins in the cycle after acceptance, with no activate and no precharge.
- R6: A request whose bank is open with a different row issues, in order: a precharge in the cycle after acceptance, an activate TRP cycles later, and a write TRCD cycles after the activate. An activate is never issued to an open bank, and a precharge is never issued to a closed bank.
- R7: A pulse on `inval_valid` marks the record of `inval_bank` stale. It puts no command on the pins by itself. The next request to that bank precharges and re-activates, even for the same row.
- R8: The first data beat is driven CL-1 cycles after the write command. `mem_wdata_en` is then high for exactly 8 consecutive cycles.
- R9: Beat i (0 to 7) drives data word i, taken from `req_data` bits [i*DQ_W +: DQ_W]. For i below `req_len`, `mem_wmask` is the inverse of byte-enable group i (`req_be` bits [i*DQ_W/8 +: DQ_W/8], where 1 means write the byte). For i at or above `req_len`, the mask is all ones and the data is 0.
- R10: `wr_done` is a single-cycle pulse in the cycle right after the last beat.
- R11: `req_ready` is 0 from the cycle after acceptance until the `wr_done` cycle, and is 1 again in that cycle. A request held valid while `req_ready` is 0 is not taken and does not change the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request is taken when both this and `req_valid` are high |
| req_addr | input | ROW_W+BA_W+COL_W | Address in memory-width units: {row, bank, column} |
| req_len | input | 4 | Number of live words, 1 to 8 |
| req_data | input | 8*DQ_W | Eight data words, word i at [i*DQ_W +: DQ_W] |
| req_be | input | 8*DQ_W/8 | Byte enables per word, 1 = write |
| inval_valid | input | 1 | Mark one bank record stale |
| inval_bank | input | BA_W | Bank to mark stale |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bank | output | BA_W | Bank address |
| mem_addr | output | A_W | Row or column address |
| mem_wdata | output | DQ_W | Write data beat |
| mem_wmask | output | DQ_W/8 | Per-byte mask, 1 = do not write |
| mem_wdata_en | output | 1 | Data beat is being driven |
| wr_done | output | 1 | Burst finished |

## Verification
Every result is tied to the acceptance edge, which is cycle 0. The first command appears in cycle 1. In a miss, the activate follows the precharge after TRP cycles, and the write follows the activate after TRCD cycles. The beats fill cycles write+CL-1 through write+CL+6. The done pulse and the return of ready come together in cycle write+CL+7. For each request the bench builds this timeline from its own model of the bank records. It then samples the outputs at every falling edge from cycle 1 to the done cycle and compares each cycle against the timeline, so a command, beat or pulse that is early or late by a single cycle is caught.

// File: rtl/ddr2_wr_pkg.sv
// Shared types for the DDR2 write sequencer.
// Assumes command pins ordered {cs_n, ras_n, cas_n, we_n}.
package ddr2_wr_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } mem_cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RP,
        SQ_RCD,
        SQ_WL,
        SQ_BURST
    } seq_state_t;

    localparam int BURST_BEATS = 8;

endpackage

// File: rtl/ddr2_bank_table.sv
// Per-bank open-row record: open flag, valid flag and row number.
// Classifies the looked-up request as closed / hit / conflict.
// Assumes at most one activate or precharge per cycle; invalidate
// overrides an activate to the same bank in the same cycle.
module ddr2_bank_table #(
    parameter int BANKS = 8,
    parameter int BA_W  = 3,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BA_W-1:0]  look_bank,
    input  logic [ROW_W-1:0] look_row,
    input  logic             act_en,
    input  logic [BA_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic             pre_en,
    input  logic [BA_W-1:0]  pre_bank,
    input  logic             inv_en,
    input  logic [BA_W-1:0]  inv_bank,
    output logic             need_act,
    output logic             need_pre,
    output logic             look_open,
    output logic             look_match
);

    logic [BANKS-1:0] open_q, valid_q;
    logic [ROW_W-1:0] row_q [BANKS];
    logic [BANKS-1:0] sel_act, sel_pre, sel_inv;

    // Per-bank decode of the update strobes.
    for (genvar g = 0; g < BANKS; g++) begin : g_dec
        assign sel_act[g] = act_en && (act_bank == BA_W'(g));
        assign sel_pre[g] = pre_en && (pre_bank == BA_W'(g));
        assign sel_inv[g] = inv_en && (inv_bank == BA_W'(g));
    end

    // Record update: precharge closes, activate opens, invalidate marks stale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= '0;
            valid_q <= '0;
            for (int b = 0; b < BANKS; b++) row_q[b] <= '0;
        end else begin
            for (int b = 0; b < BANKS; b++) begin
                if (sel_pre[b]) begin
                    open_q[b]  <= 1'b0;
                    valid_q[b] <= 1'b0;
                end else if (sel_act[b]) begin
                    open_q[b]  <= 1'b1;
                    valid_q[b] <= 1'b1;
                    row_q[b]   <= act_row;
                end
                if (sel_inv[b]) valid_q[b] <= 1'b0;
            end
        end
    end

    // Lookup classification for the current request.
    always_comb begin
        look_open  = open_q[look_bank];
        look_match = (row_q[look_bank] == look_row);
        need_act   = !look_open;
        need_pre   = look_open && !(valid_q[look_bank] && look_match);
    end

    AST_PRE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> open_q[pre_bank]); // R6
    AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !open_q[act_bank]); // R6

endmodule

// File: rtl/ddr2_cmd_seq.sv
// Command sequencer: accepts a request, issues precharge / activate /
// write with TRP and TRCD spacing, waits the write latency, then holds
// until the data path reports the last beat. Pins are registered.
// Assumes TRP, TRCD, WL >= 1 and column width <= 10 (A10 stays low).
module ddr2_cmd_seq
    import ddr2_wr_pkg::*;
#(
    parameter int BA_W  = 3,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int A_W   = 14,
    parameter int TRCD  = 2,
    parameter int TRP   = 3,
    parameter int WL    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             need_act,
    input  logic             need_pre,
    input  logic             burst_last,
    output logic             req_ready,
    output logic [BA_W-1:0]  cur_bank,
    output logic [ROW_W-1:0] cur_row,
    output logic             act_en,
    output logic [BA_W-1:0]  act_bank,
    output logic [ROW_W-1:0] act_row,
    output logic             pre_en,
    output logic [BA_W-1:0]  pre_bank,
    output logic             burst_start,
    output logic [3:0]       cmd_o,
    output logic [BA_W-1:0]  ba_o,
    output logic [A_W-1:0]   addr_o
);

    localparam int MAXD = (TRCD > TRP) ? ((TRCD > WL) ? TRCD : WL)
                                       : ((TRP > WL) ? TRP : WL);
    localparam int CW   = $clog2(MAXD + 1);

    seq_state_t       st_q, nxt_st;
    logic [CW-1:0]    cnt_q, nxt_cnt;
    mem_cmd_t         cmd_q, nxt_cmd;
    logic [BA_W-1:0]  ba_q, nxt_ba;
    logic [A_W-1:0]   addr_q, nxt_addr;
    logic [COL_W-1:0] cur_col;
    logic             take;

    // Next-state and next-command decision.
    always_comb begin
        nxt_st   = st_q;
        nxt_cnt  = cnt_q;
        nxt_cmd  = CMD_NOP;
        nxt_ba   = '0;
        nxt_addr = '0;
        take     = 1'b0;
        case (st_q)
            SQ_IDLE: if (req_valid) begin
                take   = 1'b1;
                nxt_ba = req_bank;
                if (need_pre) begin
                    nxt_cmd = CMD_PRE;
                    nxt_st  = SQ_RP;
                    nxt_cnt = CW'(TRP - 1);
                end else if (need_act) begin
                    nxt_cmd  = CMD_ACT;
                    nxt_addr = A_W'(req_row);
                    nxt_st   = SQ_RCD;
                    nxt_cnt  = CW'(TRCD - 1);
                end else begin
                    nxt_cmd  = CMD_WR;
                    nxt_addr = A_W'(req_col);
                    nxt_st   = SQ_WL;
                    nxt_cnt  = CW'(WL - 1);
                end
            end
            SQ_RP: if (cnt_q == '0) begin
                nxt_cmd  = CMD_ACT;
                nxt_ba   = cur_bank;
                nxt_addr = A_W'(cur_row);
                nxt_st   = SQ_RCD;
                nxt_cnt  = CW'(TRCD - 1);
            end else begin
                nxt_cnt = cnt_q - 1'b1;
            end
            SQ_RCD: if (cnt_q == '0) begin
                nxt_cmd  = CMD_WR;
                nxt_ba   = cur_bank;
                nxt_addr = A_W'(cur_col);
                nxt_st   = SQ_WL;
                nxt_cnt  = CW'(WL - 1);
            end else begin
                nxt_cnt = cnt_q - 1'b1;
            end
            SQ_WL: if (cnt_q == '0) nxt_st = SQ_BURST;
                   else nxt_cnt = cnt_q - 1'b1;
            SQ_BURST: if (burst_last) nxt_st = SQ_IDLE;
            default: nxt_st = SQ_IDLE;
        endcase
    end

    // Register state, request fields and pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SQ_IDLE;
            cnt_q    <= '0;
            cmd_q    <= CMD_NOP;
            ba_q     <= '0;
            addr_q   <= '0;
            cur_bank <= '0;
            cur_row  <= '0;
            cur_col  <= '0;
        end else begin
            st_q   <= nxt_st;
            cnt_q  <= nxt_cnt;
            cmd_q  <= nxt_cmd;
            ba_q   <= nxt_ba;
            addr_q <= nxt_addr;
            if (take) begin
                cur_bank <= req_bank;
                cur_row  <= req_row;
                cur_col  <= req_col;
            end
        end
    end

    assign req_ready   = (st_q == SQ_IDLE);
    assign burst_start = (st_q == SQ_WL) && (cnt_q == '0);
    assign act_en      = (nxt_cmd == CMD_ACT);
    assign act_bank    = nxt_ba;
    assign act_row     = nxt_addr[ROW_W-1:0];
    assign pre_en      = (nxt_cmd == CMD_PRE);
    assign pre_bank    = nxt_ba;
    assign cmd_o       = cmd_q;
    assign ba_o        = ba_q;
    assign addr_o      = addr_q;

    // Checker state: cycles since the last non-NOP command on the pins.
    logic [7:0] gap_q;
    mem_cmd_t   prev_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= 8'hFF;
            prev_q <= CMD_NOP;
        end else if (cmd_q != CMD_NOP) begin
            gap_q  <= 8'd1;
            prev_q <= cmd_q;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    AST_TRCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_WR && prev_q == CMD_ACT) |-> (gap_q >= 8'(TRCD))); // R4
    AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT && prev_q == CMD_PRE) |-> (gap_q >= 8'(TRP))); // R6

endmodule

// File: rtl/ddr2_data_burst.sv
// Write data path: captures the request's words, byte enables and
// length at acceptance, then drives exactly 8 beats from a start strobe.
// Beats at or beyond the length are fully masked and carry zero data.
module ddr2_data_burst #(
    parameter int DQ_W  = 32,
    parameter int NB    = 4,
    parameter int LEN_W = 4,
    parameter int BEATS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic [BEATS*DQ_W-1:0] cap_data,
    input  logic [BEATS*NB-1:0]   cap_be,
    input  logic [LEN_W-1:0]      cap_len,
    input  logic                  start,
    output logic [DQ_W-1:0]       wdata,
    output logic [NB-1:0]         wmask,
    output logic                  wen,
    output logic                  last,
    output logic                  done
);

    localparam int BW = $clog2(BEATS);

    logic [BEATS*DQ_W-1:0] data_q;
    logic [BEATS*NB-1:0]   be_q;
    logic [LEN_W-1:0]      len_q;
    logic [BW-1:0]         beat_q, nb;
    logic                  act_q, nb_live;
    logic [DQ_W-1:0]       nb_word;
    logic [NB-1:0]         nb_mask;

    // Select the next beat's word and mask.
    always_comb begin
        nb      = start ? '0 : beat_q + 1'b1;
        nb_live = (LEN_W'(nb) < len_q);
        nb_word = nb_live ? data_q[int'(nb)*DQ_W +: DQ_W] : '0;
        nb_mask = nb_live ? ~be_q[int'(nb)*NB +: NB] : '1;
    end

    // Capture at acceptance and step through the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            be_q   <= '0;
            len_q  <= '0;
            beat_q <= '0;
            act_q  <= 1'b0;
            wdata  <= '0;
            wmask  <= '1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cap_en) begin
                data_q <= cap_data;
                be_q   <= cap_be;
                len_q  <= cap_len;
            end
            if (start || (act_q && !last)) begin
                act_q  <= 1'b1;
                beat_q <= nb;
                wdata  <= nb_word;
                wmask  <= nb_mask;
            end else if (last) begin
                act_q  <= 1'b0;
                beat_q <= '0;
                wdata  <= '0;
                wmask  <= '1;
                done   <= 1'b1;
            end
        end
    end

    assign last = act_q && (beat_q == BW'(BEATS - 1));
    assign wen  = act_q;

    AST_BURST_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(act_q, 1) && $past(act_q, 8) && !$past(act_q, 9))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

// File: rtl/ddr2_wr_seq.sv
// Top of the DDR2 write sequencer: splits the request address, keeps
// per-bank open rows, sequences commands and drives the 8-beat burst.
// Assumes DQ_W of 16 or 32, CL >= 2, TRP >= 1, TRCD >= 1, ROW_W <= A_W.
module ddr2_wr_seq
    import ddr2_wr_pkg::*;
#(
    parameter int DQ_W  = 32,
    parameter int BANKS = 8,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int A_W   = 14,
    parameter int CL    = 4,
    parameter int TRCD  = 2,
    parameter int TRP   = 3,
    localparam int NB    = DQ_W / 8,
    localparam int BA_W  = $clog2(BANKS),
    localparam int AU_W  = ROW_W + BA_W + COL_W,
    localparam int BEATS = BURST_BEATS,
    localparam int LEN_W = $clog2(BURST_BEATS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AU_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [BEATS*DQ_W-1:0] req_data,
    input  logic [BEATS*NB-1:0]   req_be,
    input  logic                  inval_valid,
    input  logic [BA_W-1:0]       inval_bank,
    output logic                  mem_cs_n,
    output logic                  mem_ras_n,
    output logic                  mem_cas_n,
    output logic                  mem_we_n,
    output logic [BA_W-1:0]       mem_bank,
    output logic [A_W-1:0]        mem_addr,
    output logic [DQ_W-1:0]       mem_wdata,
    output logic [NB-1:0]         mem_wmask,
    output logic                  mem_wdata_en,
    output logic                  wr_done
);

    localparam int WL = CL - 1;

    logic [COL_W-1:0] a_col;
    logic [BA_W-1:0]  a_bank, cur_bank, look_bank, act_bank, pre_bank;
    logic [ROW_W-1:0] a_row, cur_row, look_row, act_row;
    logic             need_act, need_pre, look_open, look_match;
    logic             act_en, pre_en, burst_start, burst_last, accept;
    logic [3:0]       cmd_pins;

    // Address split: {row, bank, column} in memory-width units.
    assign a_col  = req_addr[COL_W-1:0];
    assign a_bank = req_addr[COL_W +: BA_W];
    assign a_row  = req_addr[COL_W+BA_W +: ROW_W];
    assign accept = req_valid && req_ready;

    // Look up the incoming request when idle, the held one otherwise.
    assign look_bank = req_ready ? a_bank : cur_bank;
    assign look_row  = req_ready ? a_row  : cur_row;

    ddr2_bank_table #(.BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .look_bank(look_bank), .look_row(look_row),
        .act_en(act_en), .act_bank(act_bank), .act_row(act_row),
        .pre_en(pre_en), .pre_bank(pre_bank),
        .inv_en(inval_valid), .inv_bank(inval_bank),
        .need_act(need_act), .need_pre(need_pre),
        .look_open(look_open), .look_match(look_match)
    );

    ddr2_cmd_seq #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W),
                   .TRCD(TRCD), .TRP(TRP), .WL(WL)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_bank(a_bank), .req_row(a_row), .req_col(a_col),
        .need_act(need_act), .need_pre(need_pre), .burst_last(burst_last),
        .req_ready(req_ready), .cur_bank(cur_bank), .cur_row(cur_row),
        .act_en(act_en), .act_bank(act_bank), .act_row(act_row),
        .pre_en(pre_en), .pre_bank(pre_bank), .burst_start(burst_start),
        .cmd_o(cmd_pins), .ba_o(mem_bank), .addr_o(mem_addr)
    );

    ddr2_data_burst #(.DQ_W(DQ_W), .NB(NB), .LEN_W(LEN_W), .BEATS(BEATS)) u_data (
        .clk(clk), .rst_n(rst_n),
        .cap_en(accept), .cap_data(req_data), .cap_be(req_be), .cap_len(req_len),
        .start(burst_start),
        .wdata(mem_wdata), .wmask(mem_wmask), .wen(mem_wdata_en),
        .last(burst_last), .done(wr_done)
    );

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_pins;

    AST_WR_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == CMD_WR) |-> (look_open && look_match)); // R4
    AST_WL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wdata_en) |-> $past(cmd_pins == CMD_WR, WL)); // R8
    AST_READY_LOW_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wdata_en |-> !req_ready); // R11

endmodule

// File: tb/tb_ddr2_wr_seq.sv
// Self-checking bench: per request, builds the expected cycle timeline
// from its own bank-record model and compares the pins every cycle.
module tb_ddr2_wr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DQ_W = 32, NB = 4, BANKS = 8, BA_W = 3;
    localparam int ROW_W = 13, COL_W = 10, A_W = 14;
    localparam int CL = 4, WL = CL - 1, TRCD = 2, TRP = 3;
    localparam int AU_W = ROW_W + BA_W + COL_W;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011,
                           C_WR  = 4'b0100, C_PRE = 4'b0010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [AU_W-1:0] req_addr = '0;
    logic [3:0] req_len = 4'd1;
    logic [8*DQ_W-1:0] req_data = '0;
    logic [8*NB-1:0] req_be = '0;
    logic inval_valid = 1'b0;
    logic [BA_W-1:0] inval_bank = '0;
    logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [BA_W-1:0] mem_bank;
    logic [A_W-1:0] mem_addr;
    logic [DQ_W-1:0] mem_wdata;
    logic [NB-1:0] mem_wmask;
    logic mem_wdata_en, wr_done;

    ddr2_wr_seq #(.DQ_W(DQ_W), .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
                  .A_W(A_W), .CL(CL), .TRCD(TRCD), .TRP(TRP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data), .req_be(req_be),
        .inval_valid(inval_valid), .inval_bank(inval_bank),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
        .mem_wdata_en(mem_wdata_en), .wr_done(wr_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit m_open[BANKS], m_valid[BANKS];
    int m_row[BANKS];

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [DQ_W-1:0] pat_word(int b, int r, int c, int i);
        return 32'((b << 28) ^ (r << 14) ^ (c << 4) ^ i ^ 32'h5A00_0000);
    endfunction

    function automatic logic [NB-1:0] pat_be(int b, int len, int i);
        return 4'((len + 5 * i + b) % 16);
    endfunction

    function automatic logic [3:0] pins();
        return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    endfunction

    // One request: drive it, then compare every cycle up to the done pulse.
    task automatic run_req(input int b, input int r, input int c, input int len,
                           input bit noise);
        int t_pre, t_act, t_wr, t_b0, t_done;
        string ctag;
        logic [3:0] ecmd;
        logic [A_W-1:0] eaddr;
        for (int i = 0; i < 8; i++) begin
            req_data[i*DQ_W +: DQ_W] = pat_word(b, r, c, i);
            req_be[i*NB +: NB]       = pat_be(b, len, i);
        end
        if (!m_open[b]) begin
            ctag = "R4 closed"; t_pre = -1; t_act = 1; t_wr = 1 + TRCD;
        end else if (m_valid[b] && m_row[b] == r) begin
            ctag = "R5 hit"; t_pre = -1; t_act = -1; t_wr = 1;
        end else begin
            ctag = (m_row[b] == r) ? "R7 stale" : "R6 conflict";
            t_pre = 1; t_act = 1 + TRP; t_wr = t_act + TRCD;
        end
        t_b0 = t_wr + WL;
        t_done = t_b0 + 8;
        @(negedge clk);
        req_addr  = (AU_W'(r) << (BA_W + COL_W)) | (AU_W'(b) << COL_W) | AU_W'(c);
        req_len   = 4'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= t_done; k++) begin
            if (k > 1) @(negedge clk);
            ecmd = C_NOP; eaddr = '0;
            if (k == t_pre) ecmd = C_PRE;
            else if (k == t_act) begin ecmd = C_ACT; eaddr = A_W'(r); end
            else if (k == t_wr) begin ecmd = C_WR; eaddr = A_W'(c); end
            chk(pins() == ecmd, {ctag, " R3 command"}, 64'(pins()), 64'(ecmd));
            if (ecmd != C_NOP) begin
                chk(mem_bank == BA_W'(b), "R2 bank", 64'(mem_bank), 64'(b));
                chk(mem_addr == eaddr, "R2 R3 address", 64'(mem_addr), 64'(eaddr));
            end
            if (k >= t_b0 && k < t_b0 + 8) begin
                int i = k - t_b0;
                chk(mem_wdata_en == 1'b1, "R8 beat enable", 64'(mem_wdata_en), 64'd1);
                chk(mem_wdata == ((i < len) ? pat_word(b, r, c, i) : '0),
                    "R9 data", 64'(mem_wdata),
                    64'((i < len) ? pat_word(b, r, c, i) : '0));
                chk(mem_wmask == ((i < len) ? ~pat_be(b, len, i) : 4'hF),
                    "R9 mask", 64'(mem_wmask),
                    64'((i < len) ? ~pat_be(b, len, i) : 4'hF));
            end else begin
                chk(mem_wdata_en == 1'b0, "R8 idle enable", 64'(mem_wdata_en), 64'd0);
            end
            chk(wr_done == (k == t_done), "R10 done", 64'(wr_done), 64'(k == t_done));
            chk(req_ready == (k == t_done), "R11 ready", 64'(req_ready), 64'(k == t_done));
            if (noise && k == 2) begin
                req_addr  = ~req_addr;
                req_valid = 1'b1;
            end
            if (noise && k == t_done - 1) req_valid = 1'b0;
        end
        m_open[b] = 1'b1; m_valid[b] = 1'b1; m_row[b] = r;
    endtask

    // Invalidate one bank and confirm the pins stay quiet.
    task automatic do_inval(input int b);
        @(negedge clk);
        inval_valid = 1'b1;
        inval_bank  = BA_W'(b);
        @(negedge clk);
        inval_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            chk(pins() == C_NOP, "R7 no command", 64'(pins()), 64'(C_NOP));
            chk(req_ready == 1'b1, "R7 ready", 64'(req_ready), 64'd1);
        end
        m_valid[b] = 1'b0;
    endtask

    initial begin
        for (int b = 0; b < BANKS; b++) begin
            m_open[b] = 1'b0; m_valid[b] = 1'b0; m_row[b] = 0;
        end
        repeat (3) @(negedge clk);
        chk(pins() == C_NOP, "R1 reset command", 64'(pins()), 64'(C_NOP));
        chk(mem_wmask == 4'hF, "R1 reset mask", 64'(mem_wmask), 64'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pins() == C_NOP, "R1 command", 64'(pins()), 64'(C_NOP));
        chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        chk(mem_wdata_en == 1'b0, "R1 enable", 64'(mem_wdata_en), 64'd0);
        chk(wr_done == 1'b0, "R1 done", 64'(wr_done), 64'd0);
        chk(mem_wmask == 4'hF, "R1 mask", 64'(mem_wmask), 64'hF);

        // R4: first touch of every bank.
        for (int b = 0; b < BANKS; b++) run_req(b, b + 1, b * 8, 8, 1'b0);
        // R5 R9: every length as a row hit.
        for (int len = 1; len <= 8; len++) run_req(3, 4, len * 8, len, 1'b0);
        // R6: row conflicts, then a hit on the new row.
        run_req(2, 9, 16, 5, 1'b0);
        run_req(2, 9, 24, 3, 1'b0);
        run_req(5, 2, 0, 8, 1'b0);
        // R7: stale record forces precharge even for the same row.
        do_inval(1);
        run_req(1, 2, 40, 6, 1'b0);
        run_req(1, 2, 48, 2, 1'b0);
        do_inval(7);
        run_req(7, 100, 8, 4, 1'b0);
        // R11: valid raised during a busy burst is ignored.
        run_req(0, 1, 32, 7, 1'b1);
        run_req(6, 7, 56, 1, 1'b1);
        // R2: largest row and column on the top bank.
        run_req(7, 8191, 1023, 8, 1'b0);
        run_req(7, 8191, 1016, 1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule